// File: doc/BRIEF.md
# PCM and FM Interrupt Merger

This block combines the interrupt activity of eight PCM playback channels and one FM synthesizer into one shared interrupt request line for the host. The PCM side delivers events. Each event carries a channel number, an on/off flag and a broadcast flag that addresses every channel at once. The FM side delivers a plain level. The block keeps a per-channel status byte, a per-channel enable mask and a record of whether a PCM interrupt is still outstanding. The shared line stays high while either the PCM record or the FM level is active.

The host reaches the block through an 8-bit register port. The port has a 2-bit select and one-cycle read and write strobes. A cause register tells the host which source is active. A mask register chooses which channels may raise the line. A status register returns the channel byte and clears it as a side effect of the read. A typical interrupt handler reads the cause register first and then reads the status register, which acknowledges the PCM side.

Top module: `pcm_fm_irq_merge`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the status byte, the mask, the PCM-pending record and the FM flag, and `irq_out` is low after that edge.
- R2: A single-channel event (`ev_all`=0) sets status bit `ev_chan` when `ev_on`=1 and clears it when `ev_on`=0. The mask has no effect on this. The change is visible from the next cycle.
- R3: A single-channel "on" event for a channel whose mask bit is 1 sets the PCM-pending record, and `irq_out` is high after the edge. An "on" event for a channel whose mask bit is 0 clears the record, and `irq_out` then follows the FM flag.
- R4: A broadcast event (`ev_all`=1) ignores `ev_chan`. When it is "on" it sets all eight status bits and raises `irq_out` whatever the mask holds. When it is "off" it clears all eight status bits.
- R5: Any "off" event clears the PCM-pending record. After the edge, `irq_out` is low unless `fm_irq` was high at that edge.
- R6: `fm_irq` is sampled at each edge. While it is high, `irq_out` is high after the edge. When it goes low, `irq_out` drops only if no PCM interrupt is pending.
- R7: Reading select 0 (cause) returns bit 3 = 1 when any status bit is set, bit 0 = the sampled FM flag, and 0 in all other bits. The read clears nothing.
- R8: Select 1 (mask) reads back the last value written. Bit n enables channel n, and the reset value is 0x00.
- R9: Reading select 2 (status) returns the status byte in the strobe cycle. After that edge the status byte and the PCM-pending record are clear, and `irq_out` is low unless `fm_irq` is high.
- R10: When a status read and an event fall in the same cycle, the clear is applied first and the event second. An "on" event is therefore kept in both the status byte and the pending record.
- R11: Select 3 reads 0x00. Writes to selects 0, 2 and 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Channel event strobe, one cycle |
| ev_chan | input | 3 | Channel number of the event |
| ev_on | input | 1 | 1 = interrupt on, 0 = off |
| ev_all | input | 1 | Event addresses every channel |
| fm_irq | input | 1 | FM synthesizer interrupt level |
| host_sel | input | 2 | Register select: 0 cause, 1 mask, 2 status, 3 spare |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wr | input | 1 | Write strobe, one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the strobe cycle |
| irq_out | output | 1 | Shared interrupt request, registered |

## Verification
Events, the FM level and the read-to-clear side effect all act at the clock edge that samples them. Their results on `irq_out`, on the status byte and on the cause bits are due one cycle later. Read data comes from the current state and is valid in the same cycle as the read strobe. The bench therefore changes inputs shortly after an edge and reads `host_rdata` before the next edge. It checks `irq_out` and the register contents only after the edge that consumed the stimulus. It compares them with a model of the status byte, the pending record and the FM flag, and that model is updated from the requirements.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
  typedef enum logic [1:0] {
    SEL_CAUSE  = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  localparam int CAUSE_FM_BIT  = 0;
  localparam int CAUSE_PCM_BIT = 3;
endpackage

// File: rtl/pfi_status_bank.sv
// Per-channel status bits and the PCM-pending record.
// A read-to-clear is applied first and any event second, so a new event wins.
module pfi_status_bank #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_clr,
  input  logic              ev_valid,
  input  logic [CH_W-1:0]   ev_chan,
  input  logic              ev_on,
  input  logic              ev_all,
  input  logic [NUM_CH-1:0] mask_q,
  output logic [NUM_CH-1:0] status_q,
  output logic              pend_q,
  output logic              pend_nx
);
  logic [NUM_CH-1:0] status_nx;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      logic hit;
      assign hit = ev_valid && (ev_all || (ev_chan == CH_W'(gi)));
      always_comb begin
        if (hit)         status_nx[gi] = ev_on;
        else if (rd_clr) status_nx[gi] = 1'b0;
        else             status_nx[gi] = status_q[gi];
      end
    end
  endgenerate

  always_comb begin
    if (ev_valid)    pend_nx = ev_on && (ev_all || mask_q[ev_chan]);
    else if (rd_clr) pend_nx = 1'b0;
    else             pend_nx = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      status_q <= status_nx;
      pend_q   <= pend_nx;
    end
  end
endmodule

// File: rtl/pfi_host_regs.sv
// Host register port: mask register, read mux and the read-to-clear strobe.
module pfi_host_regs
  import pfi_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        host_sel,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [NUM_CH-1:0] status_q,
  input  logic              fm_q,
  output logic [NUM_CH-1:0] mask_q,
  output logic              rd_clr,
  output logic [DATA_W-1:0] host_rdata
);
  reg_sel_e sel;
  assign sel    = reg_sel_e'(host_sel);
  assign rd_clr = host_rd && (sel == SEL_STATUS);

  always_ff @(posedge clk) begin
    if (rst)                            mask_q <= '0;
    else if (host_wr && sel == SEL_MASK) mask_q <= host_wdata[NUM_CH-1:0];
  end

  always_comb begin
    host_rdata = '0;
    case (sel)
      SEL_CAUSE: begin
        host_rdata[CAUSE_PCM_BIT] = |status_q;
        host_rdata[CAUSE_FM_BIT]  = fm_q;
      end
      SEL_MASK:   host_rdata = DATA_W'(mask_q);
      SEL_STATUS: host_rdata = DATA_W'(status_q);
      default:    host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pcm_fm_irq_merge.sv
// Shared interrupt line for eight PCM channels and one FM source.
module pcm_fm_irq_merge #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [CH_W-1:0]   ev_chan,
  input  logic              ev_on,
  input  logic              ev_all,
  input  logic              fm_irq,
  input  logic [1:0]        host_sel,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq_out
);
  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] status_q;
  logic              rd_clr;
  logic              pend_q;
  logic              pend_nx;
  logic              fm_q;

  pfi_host_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .host_sel   (host_sel),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .status_q   (status_q),
    .fm_q       (fm_q),
    .mask_q     (mask_q),
    .rd_clr     (rd_clr),
    .host_rdata (host_rdata)
  );

  pfi_status_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .rd_clr   (rd_clr),
    .ev_valid (ev_valid),
    .ev_chan  (ev_chan),
    .ev_on    (ev_on),
    .ev_all   (ev_all),
    .mask_q   (mask_q),
    .status_q (status_q),
    .pend_q   (pend_q),
    .pend_nx  (pend_nx)
  );

  // The line is high while either a PCM interrupt is pending or FM is active.
  always_ff @(posedge clk) begin
    if (rst) begin
      fm_q    <= 1'b0;
      irq_out <= 1'b0;
    end else begin
      fm_q    <= fm_irq;
      irq_out <= pend_nx | fm_irq;
    end
  end
endmodule

// File: rtl/pfi_checker.sv
module pfi_checker #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic [CH_W-1:0]   ev_chan,
  input logic              ev_on,
  input logic              ev_all,
  input logic              fm_irq,
  input logic [1:0]        host_sel,
  input logic              host_rd,
  input logic              host_wr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              irq_out,
  input logic [NUM_CH-1:0] mask_q,
  input logic [NUM_CH-1:0] status_q
);
  logic rd_status;
  assign rd_status = host_rd && (host_sel == 2'd2);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!irq_out && mask_q == '0 && status_q == '0));

  assert_chan_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_all) |=> (status_q[$past(ev_chan)] == $past(ev_on)));

  assert_unmasked_raise_R3: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_on && !ev_all && mask_q[ev_chan]) |=> irq_out);

  assert_broadcast_on_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_all && ev_on) |=> (irq_out && status_q == '1));

  assert_off_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_on && !fm_irq) |=> !irq_out);

  assert_fm_raise_R6: assert property (@(posedge clk) disable iff (rst)
    fm_irq |=> irq_out);

  assert_mask_write_R8: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_sel == 2'd1) |=> (mask_q == $past(host_wdata[NUM_CH-1:0])));

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !ev_valid && !fm_irq) |=> (!irq_out && status_q == '0));

  assert_cause_read_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_sel == 2'd0 && !ev_valid) |=> $stable(status_q));
endmodule

bind pcm_fm_irq_merge pfi_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ev_valid   (ev_valid),
  .ev_chan    (ev_chan),
  .ev_on      (ev_on),
  .ev_all     (ev_all),
  .fm_irq     (fm_irq),
  .host_sel   (host_sel),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .irq_out    (irq_out),
  .mask_q     (mask_q),
  .status_q   (status_q)
);

// File: tb/sim_pcm_fm_irq_merge.sv
module sim_pcm_fm_irq_merge;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_valid = 1'b0;
  logic [2:0] ev_chan = '0;
  logic       ev_on = 1'b0;
  logic       ev_all = 1'b0;
  logic       fm_irq = 1'b0;
  logic [1:0] host_sel = '0;
  logic       host_rd = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // model state, updated from the requirements
  logic [7:0] m_status = '0;
  logic [7:0] m_mask   = '0;
  logic       m_pend   = 1'b0;
  logic       m_fm     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_fm_irq_merge u0 (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_chan(ev_chan), .ev_on(ev_on),
    .ev_all(ev_all), .fm_irq(fm_irq), .host_sel(host_sel), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cause_exp();
    return {4'b0, |m_status, 2'b0, m_fm};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send_ev(input logic [2:0] ch, input logic on, input logic all);
    ev_valid = 1'b1; ev_chan = ch; ev_on = on; ev_all = all;
    tick();
    ev_valid = 1'b0; ev_all = 1'b0;
    if (all) m_status = on ? 8'hFF : 8'h00;
    else     m_status[ch] = on;
    m_pend = on && (all || m_mask[ch]);
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [7:0] data);
    host_sel = sel; host_rd = 1'b1;
    #1 data = host_rdata;
    tick();
    host_rd = 1'b0;
    if (sel == 2'd2) begin m_status = '0; m_pend = 1'b0; end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] data);
    host_sel = sel; host_wr = 1'b1; host_wdata = data;
    tick();
    host_wr = 1'b0;
    if (sel == 2'd1) m_mask = data;
  endtask

  task automatic set_fm(input logic v);
    fm_irq = v;
    tick();
    m_fm = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    check("R1 line", {7'b0, irq_out}, 8'h00);
    rd_reg(2'd1, d); check("R1 mask", d, 8'h00);
    rd_reg(2'd0, d); check("R1 cause", d, 8'h00);

    // R2 R3 R5 R7 R8 R9: sweep masks and channels
    foreach (m_status[k]) begin end
    for (int mi = 0; mi < 4; mi++) begin
      logic [7:0] mv;
      mv = (mi == 0) ? 8'h00 : (mi == 1) ? 8'hFF : (mi == 2) ? 8'hA5 : 8'h5A;
      wr_reg(2'd1, mv);
      rd_reg(2'd1, d); check("R8 mask readback", d, mv);
      for (int ch = 0; ch < 8; ch++) begin
        send_ev(3'(ch), 1'b1, 1'b0);
        check("R3 line after on", {7'b0, irq_out}, {7'b0, m_pend | m_fm});
        rd_reg(2'd0, d); check("R7 cause", d, cause_exp());
        rd_reg(2'd0, d); check("R7 cause no clear", d, cause_exp());
        rd_reg(2'd2, d); check("R2 R9 status", d, 8'(1 << ch));
        check("R9 line after read", {7'b0, irq_out}, 8'h00);
        send_ev(3'(ch), 1'b1, 1'b0);
        send_ev(3'(ch), 1'b0, 1'b0);
        check("R5 line after off", {7'b0, irq_out}, 8'h00);
        rd_reg(2'd2, d); check("R2 off clears bit", d, 8'h00);
      end
    end

    // R4: broadcast with mask 0
    wr_reg(2'd1, 8'h00);
    send_ev(3'd2, 1'b1, 1'b1);
    check("R4 broadcast line", {7'b0, irq_out}, 8'h01);
    rd_reg(2'd0, d); check("R4 cause", d, 8'h08);
    send_ev(3'd6, 1'b0, 1'b1);
    check("R4 broadcast off line", {7'b0, irq_out}, 8'h00);
    rd_reg(2'd2, d); check("R4 broadcast off status", d, 8'h00);

    // R3: masked on while unmasked pending drops line
    wr_reg(2'd1, 8'h01);
    send_ev(3'd0, 1'b1, 1'b0);
    check("R3 unmasked raise", {7'b0, irq_out}, 8'h01);
    send_ev(3'd1, 1'b1, 1'b0);
    check("R3 masked on drops", {7'b0, irq_out}, 8'h00);
    rd_reg(2'd2, d); check("R2 masked bit kept", d, 8'h03);

    // R6: FM alone and FM with pending PCM
    set_fm(1'b1);
    check("R6 fm raise", {7'b0, irq_out}, 8'h01);
    rd_reg(2'd0, d); check("R6 R7 cause fm", d, 8'h01);
    send_ev(3'd4, 1'b0, 1'b0);
    check("R5 off keeps fm line", {7'b0, irq_out}, 8'h01);
    rd_reg(2'd2, d); check("R9 read keeps fm line", {7'b0, irq_out}, 8'h01);
    set_fm(1'b0);
    check("R6 fm fall no pend", {7'b0, irq_out}, 8'h00);
    send_ev(3'd0, 1'b1, 1'b0);
    set_fm(1'b1);
    set_fm(1'b0);
    check("R6 fm fall with pend", {7'b0, irq_out}, 8'h01);
    rd_reg(2'd2, d); check("R9 status", d, 8'h01);
    check("R9 line drop", {7'b0, irq_out}, 8'h00);

    // R10: read-to-clear and new event in the same cycle
    wr_reg(2'd1, 8'hFF);
    send_ev(3'd3, 1'b1, 1'b0);
    ev_valid = 1'b1; ev_chan = 3'd5; ev_on = 1'b1; ev_all = 1'b0;
    rd_reg(2'd2, d);
    ev_valid = 1'b0;
    check("R10 read value", d, 8'h08);
    check("R10 line kept", {7'b0, irq_out}, 8'h01);
    m_status = 8'h20; m_pend = 1'b1;
    rd_reg(2'd2, d); check("R10 event kept", d, 8'h20);

    // R11: spare select and ignored writes
    send_ev(3'd7, 1'b1, 1'b0);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd3, 8'h55);
    rd_reg(2'd3, d); check("R11 spare reads 0", d, 8'h00);
    rd_reg(2'd1, d); check("R11 mask untouched", d, 8'hFF);
    rd_reg(2'd2, d); check("R11 status untouched", d, 8'h80);

    // R1: reset mid-run
    send_ev(3'd1, 1'b1, 1'b1);
    rst = 1'b1; tick(); rst = 1'b0; tick();
    m_status = '0; m_mask = '0; m_pend = 1'b0; m_fm = 1'b0;
    check("R1 reset line", {7'b0, irq_out}, 8'h00);
    rd_reg(2'd2, d); check("R1 reset status", d, 8'h00);
    rd_reg(2'd1, d); check("R1 reset mask", d, 8'h00);

    finish_run();
  end
endmodule